// File: doc/BRIEF.md
# Block Cipher Mode Chaining Controller

This block sits between a data stream and an external 128-bit block cipher engine. It applies the chaining, the pre-processing and the post-processing for five confidentiality modes: electronic codebook, cipher block chaining, output feedback, cipher feedback and counter. It handles encryption and decryption. The block holds a 128-bit initialization vector register, a working chaining register and a small configuration register. The configuration register holds the operating mode, the direction and the cipher-feedback segment width.

A caller writes the configuration and the initialization vector, then offers one block or segment at a time on the input handshake. For each input the controller drives one request to the engine and holds it until the engine acknowledges. It then emits a one-cycle result and advances its chaining state, with no software action between blocks. The engine may be any invertible 128-bit permutation. The cipher feedback mode has five segment widths. The counter mode increments only a 16-bit field and wraps it silently.

Top module: `cmc_top`

## Requirements
- R1: After reset, `inReady` is 1, and `outValid` and `engReq` are 0.
- R2: An input is taken on a clock edge where `inValid` and `inReady` are both 1. From the next cycle, `engReq` stays 1 and `engIn` stays stable until the first edge at which `engAck` is 1. `outValid` is a single-cycle pulse in the cycle after that edge. `inReady` is 0 from acceptance until the pulse has ended.
- R3: With `cfgMode` = 0 (ECB), `engIn` is the input block, `engDecrypt` equals `cfgDecrypt`, and the output is the engine result. Codes 5 to 7 behave like 0.
- R4: With `cfgMode` = 1 (CBC), encryption sends input XOR chain to the engine, and both the output and the new chain are the engine result. Decryption sends the input to the engine and outputs the engine result XOR chain; the input ciphertext becomes the new chain. Encrypting and then decrypting with the same IV returns the plaintext.
- R5: With `cfgMode` = 2 (OFB), the chain is sent to the engine, the output is the engine result XOR input, and the engine result becomes the new chain.
- R6: With `cfgMode` = 3 (CFB), `cfgSegSel` selects the segment width s: 0→8, 1→16, 2→32, 3→64, 4 to 7→128 bits. The segment sits in the low s bits of `inData`. The output's low s bits are the input segment XOR the top s bits of the engine result, and its upper bits are 0. The chain shifts left by s and takes the ciphertext segment in at the low end. In encryption the ciphertext segment is the output; in decryption it is the input.
- R7: With `cfgMode` = 4 (CTR), the chain is sent to the engine and the output is the engine result XOR input. Only chain bits 15:0 then increment, wrapping from 16'hFFFF to 0 with no carry into bit 16.
- R8: In OFB, CFB and CTR, `engDecrypt` is 0 whatever `cfgDecrypt` says.
- R9: Writing the IV (`ivWe`) loads the chain with `ivData`. A configuration write (`cfgWe`) reloads the chain from the stored IV. Either way, the next block chains from the IV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgMode | input | 3 | Operating mode code |
| cfgDecrypt | input | 1 | 1 selects decryption |
| cfgSegSel | input | 3 | CFB segment width code |
| ivWe | input | 1 | IV write strobe |
| ivData | input | 128 | IV value |
| inValid | input | 1 | Input block offered |
| inReady | output | 1 | Controller can take an input |
| inData | input | 128 | Input block or right-aligned segment |
| outValid | output | 1 | Result pulse |
| outData | output | 128 | Result block or right-aligned segment |
| engReq | output | 1 | Request to the engine |
| engDecrypt | output | 1 | Engine direction, 1 for inverse |
| engIn | output | 128 | Engine input block |
| engAck | input | 1 | Engine result valid |
| engOut | input | 128 | Engine result |

## Verification
After the acceptance edge, `engReq` and `engIn` are due one cycle later. The result pulse is due exactly one cycle after the edge that sees `engAck`. The bench plays the engine itself and acknowledges after 0, 1 or 2 extra cycles. It samples at the falling edge that follows each of these rising edges, and it checks that the pulse has gone and `inReady` has returned one cycle after that. Expected engine inputs and outputs come from an arithmetic model of each mode that the bench keeps.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int BLK_W  = 128;
  localparam int MODE_W = 3;
  localparam int SEG_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_ECB = 3'd0,
    MODE_CBC = 3'd1,
    MODE_OFB = 3'd2,
    MODE_CFB = 3'd3,
    MODE_CTR = 3'd4
  } cmcMode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_EMIT} cmcState_t;

  typedef struct packed {
    logic load;     // accept input block
    logic capture;  // engine result arrives
  } cmcStrobe_t;

  // segment width in bits for a CFB width code
  function automatic logic [7:0] segWidth(input logic [SEG_W-1:0] sel);
    case (sel)
      3'd0:    return 8'd8;
      3'd1:    return 8'd16;
      3'd2:    return 8'd32;
      3'd3:    return 8'd64;
      default: return 8'd128;
    endcase
  endfunction
endpackage

// File: rtl/cmc_ctrl.sv
module cmc_ctrl
  import cmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       engAck,
  output logic       inReady,
  output logic       engReq,
  output logic       outValid,
  output cmcStrobe_t st
);
  cmcState_t stateQ;

  assign inReady    = (stateQ == ST_IDLE);
  assign engReq     = (stateQ == ST_WAIT);
  assign outValid   = (stateQ == ST_EMIT);
  assign st.load    = inValid && inReady;
  assign st.capture = engReq && engAck;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else begin
      case (stateQ)
        ST_IDLE: if (st.load) stateQ <= ST_WAIT;
        ST_WAIT: if (st.capture) stateQ <= ST_EMIT;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engReq && !engAck) |=> engReq);
  // R2
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engReq || outValid) |-> !inReady);
  // R2
  ack_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engReq && engAck) |=> outValid);
endmodule

// File: rtl/cmc_datapath.sv
module cmc_datapath
  import cmc_pkg::*;
#(
  parameter int CTR_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  cmcStrobe_t          st,
  input  logic                cfgWe,
  input  logic [MODE_W-1:0]   cfgMode,
  input  logic                cfgDecrypt,
  input  logic [SEG_W-1:0]    cfgSegSel,
  input  logic                ivWe,
  input  logic [BLK_W-1:0]    ivData,
  input  logic [BLK_W-1:0]    inData,
  input  logic [BLK_W-1:0]    engOut,
  output logic                engDecrypt,
  output logic [BLK_W-1:0]    engIn,
  output logic [BLK_W-1:0]    outData
);
  localparam logic [7:0] FULL_W = 8'(BLK_W);

  cmcMode_t           modeQ;
  logic               decQ;
  logic [SEG_W-1:0]   segQ;
  logic [BLK_W-1:0]   ivQ, chainQ, inQ, outQ;
  logic [BLK_W-1:0]   chainNext, resNext, segMask, keyStream, cfbOut, ctSeg;
  logic [7:0]         segW;
  logic               fwdOnly;

  assign segW      = segWidth(segQ);
  assign segMask   = (segW == FULL_W) ? '1 : ((BLK_W'(1) << segW) - BLK_W'(1));
  assign keyStream = engOut >> (FULL_W - segW);
  assign cfbOut    = (keyStream ^ inQ) & segMask;
  assign ctSeg     = decQ ? (inQ & segMask) : cfbOut;
  assign fwdOnly   = (modeQ == MODE_OFB) || (modeQ == MODE_CFB) || (modeQ == MODE_CTR);
  assign engDecrypt = decQ && !fwdOnly;
  assign outData  = outQ;

  always_comb begin
    engIn     = inQ;
    resNext   = engOut;
    chainNext = chainQ;
    case (modeQ)
      MODE_CBC: begin
        if (decQ) begin
          resNext   = engOut ^ chainQ;
          chainNext = inQ;
        end else begin
          engIn     = inQ ^ chainQ;
          chainNext = engOut;
        end
      end
      MODE_OFB: begin
        engIn     = chainQ;
        resNext   = engOut ^ inQ;
        chainNext = engOut;
      end
      MODE_CFB: begin
        engIn     = chainQ;
        resNext   = cfbOut;
        chainNext = (segW == FULL_W) ? ctSeg : ((chainQ << segW) | ctSeg);
      end
      MODE_CTR: begin
        engIn     = chainQ;
        resNext   = engOut ^ inQ;
        chainNext = {chainQ[BLK_W-1:CTR_W], chainQ[CTR_W-1:0] + CTR_W'(1)};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_ECB;
      decQ   <= 1'b0;
      segQ   <= '0;
      ivQ    <= '0;
      chainQ <= '0;
      inQ    <= '0;
      outQ   <= '0;
    end else begin
      if (cfgWe) begin
        modeQ <= cmcMode_t'(cfgMode);
        decQ  <= cfgDecrypt;
        segQ  <= cfgSegSel;
      end
      if (ivWe) begin
        ivQ    <= ivData;
        chainQ <= ivData;
      end else if (cfgWe) chainQ <= ivQ;
      else if (st.capture) chainQ <= chainNext;
      if (st.load) inQ <= inData;
      if (st.capture) outQ <= resNext;
    end
  end

  // R7
  ctr_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.capture && modeQ == MODE_CTR && !ivWe && !cfgWe)
      |=> chainQ[BLK_W-1:CTR_W] == $past(chainQ[BLK_W-1:CTR_W]));
  // R6
  cfb_narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.capture && modeQ == MODE_CFB && segQ == 3'd0) |=> outQ[BLK_W-1:8] == '0);
  // R8
  fwd_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_OFB || modeQ == MODE_CTR) |-> !engDecrypt);
  // R2
  in_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.load && $past(!st.load)) |-> $stable(inQ));
endmodule

// File: rtl/cmc_top.sv
module cmc_top
  import cmc_pkg::*;
#(
  parameter int CTR_W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWe,
  input  logic [2:0]   cfgMode,
  input  logic         cfgDecrypt,
  input  logic [2:0]   cfgSegSel,
  input  logic         ivWe,
  input  logic [127:0] ivData,
  input  logic         inValid,
  output logic         inReady,
  input  logic [127:0] inData,
  output logic         outValid,
  output logic [127:0] outData,
  output logic         engReq,
  output logic         engDecrypt,
  output logic [127:0] engIn,
  input  logic         engAck,
  input  logic [127:0] engOut
);
  cmcStrobe_t st;

  cmc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .engAck(engAck),
    .inReady(inReady), .engReq(engReq), .outValid(outValid), .st(st)
  );

  cmc_datapath #(.CTR_W(CTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cfgWe(cfgWe), .cfgMode(cfgMode),
    .cfgDecrypt(cfgDecrypt), .cfgSegSel(cfgSegSel), .ivWe(ivWe), .ivData(ivData),
    .inData(inData), .engOut(engOut), .engDecrypt(engDecrypt), .engIn(engIn),
    .outData(outData)
  );
endmodule

// File: tb/sim_cmc_top.sv
module sim_cmc_top;
  localparam int CLK_P = 10;
  localparam logic [127:0] KEYC = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 0, cfgDecrypt = 0, ivWe = 0, inValid = 0, engAck = 0;
  logic [2:0] cfgMode = 0, cfgSegSel = 0;
  logic [127:0] ivData = '0, inData = '0, engOut = '0;
  logic inReady, outValid, engReq, engDecrypt;
  logic [127:0] outData, engIn;

  int checks = 0, fails = 0;
  logic [127:0] refChain = '0, refIv = '0, lastOut, lastEngIn;
  logic [2:0] rMode = 0, rSeg = 0;
  logic rDec = 0;

  always #(CLK_P/2) clk = ~clk;

  cmc_top u0 (.*);

  function automatic logic [127:0] fwd(input logic [127:0] x);
    return {x[122:0], x[127:123]} ^ KEYC;
  endfunction
  function automatic logic [127:0] inv(input logic [127:0] y);
    logic [127:0] t;
    t = y ^ KEYC;
    return {t[4:0], t[127:5]};
  endfunction
  function automatic int sBits(input logic [2:0] s);
    return (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 32 : (s == 3) ? 64 : 128;
  endfunction
  function automatic string tagOf(input logic [2:0] m);
    case (m)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // arithmetic model of one block
  task automatic refBlock(input logic [127:0] x, output logic [127:0] eIn,
                          output logic eDec, output logic [127:0] y);
    int s;
    logic [127:0] e, mask, ct;
    s = sBits(rSeg);
    eDec = 1'b0;
    case (rMode)
      3'd1: if (!rDec) begin
              eIn = x ^ refChain; y = fwd(eIn); refChain = y;
            end else begin
              eIn = x; eDec = 1'b1; y = inv(x) ^ refChain; refChain = x;
            end
      3'd2: begin eIn = refChain; e = fwd(eIn); y = e ^ x; refChain = e; end
      3'd3: begin
              eIn = refChain; e = fwd(eIn);
              mask = (s == 128) ? '1 : ((128'd1 << s) - 128'd1);
              y = ((e >> (128 - s)) ^ x) & mask;
              ct = rDec ? (x & mask) : y;
              refChain = (s == 128) ? ct : ((refChain << s) | ct);
            end
      3'd4: begin
              eIn = refChain; y = fwd(eIn) ^ x;
              refChain[15:0] = refChain[15:0] + 16'd1;
            end
      default: begin eIn = x; eDec = rDec; y = rDec ? inv(x) : fwd(x); end
    endcase
  endtask

  task automatic writeCfg(input logic [2:0] m, input logic d, input logic [2:0] s);
    @(negedge clk);
    cfgWe = 1; cfgMode = m; cfgDecrypt = d; cfgSegSel = s;
    @(negedge clk);
    cfgWe = 0;
    rMode = m; rDec = d; rSeg = s; refChain = refIv; // R9
  endtask

  task automatic writeIv(input logic [127:0] v);
    @(negedge clk);
    ivWe = 1; ivData = v;
    @(negedge clk);
    ivWe = 0;
    refIv = v; refChain = v;
  endtask

  task automatic runBlock(input logic [127:0] x, input int lat);
    logic [127:0] eIn, y;
    logic eDec;
    string t;
    t = tagOf(rMode);
    refBlock(x, eIn, eDec, y);
    @(negedge clk); inValid = 1; inData = x;
    @(negedge clk); inValid = 0; inData = ~x;
    chk(engReq && !inReady, "R2", {126'd0, engReq, inReady}, 128'd2);
    chk(engIn == eIn, t, engIn, eIn);
    chk(engDecrypt == eDec, (rMode >= 2 && rMode <= 4) ? "R8" : t, 128'(engDecrypt), 128'(eDec));
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(engReq && engIn == eIn && !outValid, "R2", engIn, eIn);
    end
    engOut = engDecrypt ? inv(engIn) : fwd(engIn);
    lastEngIn = engIn;
    engAck = 1;
    @(negedge clk); engAck = 0; engOut = '0;
    chk(outValid && !engReq, "R2", 128'(outValid), 128'd1);
    chk(outData == y, t, outData, y);
    lastOut = outData;
    @(negedge clk);
    chk(!outValid && inReady && !engReq, "R2", {125'd0, outValid, inReady, engReq}, 128'd2);
  endtask

  function automatic logic [127:0] pat(input int m, input int d, input int s, input int b);
    return {32'h9E3779B9 * 32'(b + 1), 32'hA5A50000 ^ 32'(m * 256 + s),
            32'h01234567 + 32'(d * 77 + b), 32'hFEDCBA98 ^ 32'(b * 131 + m)};
  endfunction

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] pt [3];
    repeat (3) @(negedge clk);
    // R1
    chk(inReady && !outValid && !engReq, "R1", {125'd0, inReady, outValid, engReq}, 128'd4);
    rstN = 1;
    // sweep all modes, directions and CFB widths
    for (int m = 0; m < 6; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int s = 0; s < ((m == 3) ? 6 : 1); s++) begin
          writeCfg(3'(m), d[0], (m == 3) ? 3'(s) : 3'd4);
          writeIv(pat(m + 9, d, s, 40));
          for (int b = 0; b < 4; b++) runBlock(pat(m, d, s, b), b % 3);
        end
      end
    end
    // R4 round trip
    writeIv(128'h00112233_44556677_8899AABB_CCDDEEFF);
    writeCfg(3'd1, 1'b0, 3'd4);
    for (int b = 0; b < 3; b++) begin pt[b] = pat(7, 0, 0, b); runBlock(pt[b], 1); end
    writeCfg(3'd1, 1'b1, 3'd4);
    refChain = refIv;
    for (int b = 0; b < 3; b++) begin
      runBlock(fwd(pt[b] ^ ((b == 0) ? refIv : fwd(pt[b-1] ^ ((b == 1) ? refIv : fwd(pt[0] ^ refIv))))), 0);
      chk(lastOut == pt[b], "R4", lastOut, pt[b]);
    end
    // R6 CFB8 round trip
    writeCfg(3'd3, 1'b0, 3'd0);
    runBlock(128'h5A, 0); pt[0] = lastOut;
    runBlock(128'hC3, 2); pt[1] = lastOut;
    writeCfg(3'd3, 1'b1, 3'd0);
    runBlock(pt[0], 0);
    chk(lastOut == 128'h5A, "R6", lastOut, 128'h5A);
    runBlock(pt[1], 1);
    chk(lastOut == 128'hC3, "R6", lastOut, 128'hC3);
    // R7 counter wrap
    writeCfg(3'd4, 1'b1, 3'd0);
    writeIv(128'hDEADBEEF_01020304_0506FFFF_0000FFFE);
    for (int b = 0; b < 3; b++) runBlock(pat(4, 1, 0, b), 0);
    chk(lastEngIn == 128'hDEADBEEF_01020304_0506FFFF_00000000, "R7", lastEngIn,
        128'hDEADBEEF_01020304_0506FFFF_00000000);
    // R9 configuration write restarts chaining from the IV
    writeIv(128'h13579BDF_2468ACE0_0F0F0F0F_F0F0F0F0);
    writeCfg(3'd1, 1'b0, 3'd4);
    runBlock(pat(1, 0, 0, 1), 0);
    runBlock(pat(1, 0, 0, 2), 1);
    writeCfg(3'd1, 1'b0, 3'd4);
    runBlock(pat(1, 0, 0, 3), 0);
    chk(lastEngIn == (pat(1, 0, 0, 3) ^ refIv), "R9", lastEngIn, pat(1, 0, 0, 3) ^ refIv);
    writeIv(128'h1);
    runBlock(128'h0, 0);
    chk(lastEngIn == 128'h1, "R9", lastEngIn, 128'h1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule